// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block owns the output-compare flip-flop of one channel of an 8-bit timer and decides what appears on the associated I/O pin. It sits between the timer's waveform logic and a general-purpose port bit. Each compare-match pulse and each force strobe become one action on the flip-flop: hold, toggle, clear or set. In non-PWM operation the action comes from a 2-bit compare-output-mode field. In PWM operation it comes from the waveform generator.

The pin override and the pin direction are independent. A nonzero mode field routes the flip-flop onto the pin data path in place of the port data bit, whatever the timer mode. The port direction bit alone decides whether the pin is driven. Software can load the flip-flop with a chosen level through a preset strobe, so the pin starts from a known level when it is later turned into an output.

Top module: `tcmp_pin_unit`

## Requirements
- R1: After reset, `ocf_o` equals the parameter `RESET_LEVEL` (default 0), and `pin_oe_o` is 0 while `port_dir_i` is 0.
- R2: With `port_dir_i`=1 and `com_mode_i`=00, `pin_o` follows `port_data_i` combinationally, and `pin_oe_o`=1.
- R3: With `port_dir_i`=1 and `com_mode_i` nonzero, `pin_o` equals `ocf_o` in both PWM and non-PWM operation, and `port_data_i` has no effect on it.
- R4: With `port_dir_i`=0, `pin_oe_o`=0 and `pin_o` equals the parameter `HIZ_LEVEL` (default 0), whatever the mode field, flip-flop or port data.
- R5: In non-PWM operation (`pwm_mode_i`=0), a compare match changes the flip-flop on the next clock edge according to `com_mode_i`: 01 toggles it, 10 clears it, 11 sets it, and 00 leaves it unchanged.
- R6: The mode field acts only when a match or a force occurs. Changing `com_mode_i` with no match and no force leaves `ocf_o` unchanged, and the next match uses the value present in that match cycle.
- R7: In non-PWM operation, a force strobe applies the `com_mode_i` action on the next clock edge with no compare match present.
- R8: While `pwm_mode_i`=1, a force strobe without a match leaves `ocf_o` unchanged.
- R9: While `pwm_mode_i`=1, a compare match applies the action on `wg_act_i` (00 hold, 01 toggle, 10 clear, 11 set), and `com_mode_i` has no effect on the flip-flop.
- R10: `preset_we_i`=1 loads `preset_val_i` into the flip-flop on the next edge and overrides any match or force in the same cycle.
- R11: A match and a force in the same non-PWM cycle apply the action once, so a toggle inverts the flip-flop a single time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_match_i | input | 1 | One-cycle compare-match pulse |
| force_i | input | 1 | One-cycle force strobe |
| pwm_mode_i | input | 1 | 1 while a PWM waveform mode is selected |
| com_mode_i | input | 2 | Compare-output-mode field |
| wg_act_i | input | 2 | Action supplied by the waveform generator in PWM operation |
| preset_we_i | input | 1 | Load strobe for the flip-flop |
| preset_val_i | input | 1 | Level loaded by the preset strobe |
| port_data_i | input | 1 | Port data bit |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| pin_o | output | 1 | Pin data value |
| pin_oe_o | output | 1 | Pin output enable |
| ocf_o | output | 1 | Current compare output flip-flop value |

## Verification
The hardest situation to reach is a cycle in which several sources try to change the flip-flop at once: a preset together with a match, or a force together with a toggling match. A single cycle can also carry a mode change that must not act before its match. The stimulus drives these combinations on purpose in single cycles, and it changes the mode field over several idle cycles before issuing a match. The pin path is also checked with the direction bit cleared while the flip-flop changes underneath, and with PWM selected while the override is active.

// File: rtl/tcmp_pin_pkg.sv
package tcmp_pin_pkg;

   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      OC_HOLD   = 2'b00,
      OC_TOGGLE = 2'b01,
      OC_CLEAR  = 2'b10,
      OC_SET    = 2'b11
   } oc_act_e;

   function automatic oc_act_e field_to_act(input logic [MODE_W-1:0] fld);
      oc_act_e a;
      case (fld)
         2'b01:   a = OC_TOGGLE;
         2'b10:   a = OC_CLEAR;
         2'b11:   a = OC_SET;
         default: a = OC_HOLD;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/tcmp_act_sel.sv
module tcmp_act_sel
   import tcmp_pin_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              match,
   input  logic              force_stb,
   input  logic              pwm_mode,
   input  logic [MODE_W-1:0] mode_fld,
   input  logic [MODE_W-1:0] wg_act,
   output oc_act_e           act
);

   logic nonpwm_event;
   assign nonpwm_event = !pwm_mode && (match || force_stb);

   always_comb begin
      act = OC_HOLD;
      if (nonpwm_event)
         act = field_to_act(mode_fld);
      else if (pwm_mode && match)
         act = field_to_act(wg_act);
   end

   // R8: in PWM operation a lone force strobe yields no action
   a_r8_force_ignored_pwm: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode && force_stb && !match) |-> (act == OC_HOLD));

   // R6: without match or force no action is produced
   a_r6_no_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!match && !force_stb) |-> (act == OC_HOLD));

endmodule

// File: rtl/tcmp_ocff.sv
module tcmp_ocff
   import tcmp_pin_pkg::*;
#(
   parameter int RESET_LEVEL = 0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  oc_act_e act,
   input  logic    preset_we,
   input  logic    preset_val,
   output logic    q
);

   localparam logic RST_Q = (RESET_LEVEL != 0);

   if (RESET_LEVEL < 0 || RESET_LEVEL > 1) begin : g_bad_reset
      $error("tcmp_ocff: RESET_LEVEL must be 0 or 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_Q;
      else if (preset_we)
         q <= preset_val;
      else begin
         case (act)
            OC_TOGGLE: q <= ~q;
            OC_CLEAR:  q <= 1'b0;
            OC_SET:    q <= 1'b1;
            default:   q <= q;
         endcase
      end
   end

   // R10: preset loads the chosen level
   a_r10_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
      preset_we |=> (q == $past(preset_val)));

   // R5: no action keeps the flip-flop
   a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!preset_we && act == OC_HOLD) |=> $stable(q));

   // R11: a toggle inverts exactly once
   a_r11_toggle_once: assert property (@(posedge clk) disable iff (!rst_n)
      (!preset_we && act == OC_TOGGLE) |=> (q != $past(q)));

   // R5: clear and set reach their levels
   a_r5_clear_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!preset_we && (act == OC_CLEAR || act == OC_SET)) |=> (q == $past(act == OC_SET)));

endmodule

// File: rtl/tcmp_pin_mux.sv
module tcmp_pin_mux
   import tcmp_pin_pkg::*;
#(
   parameter int HIZ_LEVEL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_fld,
   input  logic              ocf,
   input  logic              port_data,
   input  logic              port_dir,
   output logic              pin,
   output logic              pin_oe
);

   localparam logic IDLE_LVL = (HIZ_LEVEL != 0);

   if (HIZ_LEVEL < 0 || HIZ_LEVEL > 1) begin : g_bad_hiz
      $error("tcmp_pin_mux: HIZ_LEVEL must be 0 or 1");
   end

   logic override;
   logic data_sel;

   assign override = |mode_fld;
   assign data_sel = override ? ocf : port_data;
   assign pin_oe   = port_dir;
   assign pin      = port_dir ? data_sel : IDLE_LVL;

   // R4: undriven pin rests at the idle level
   a_r4_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
      !port_dir |-> (!pin_oe && pin == IDLE_LVL));

   // R3: nonzero mode routes the flip-flop to a driven pin
   a_r3_override: assert property (@(posedge clk) disable iff (!rst_n)
      (port_dir && mode_fld != 2'b00) |-> (pin == ocf));

   // R2: mode 00 shows port data
   a_r2_port_data: assert property (@(posedge clk) disable iff (!rst_n)
      (port_dir && mode_fld == 2'b00) |-> (pin == port_data));

endmodule

// File: rtl/tcmp_pin_unit.sv
module tcmp_pin_unit
   import tcmp_pin_pkg::*;
#(
   parameter int RESET_LEVEL = 0,
   parameter int HIZ_LEVEL   = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmp_match_i,
   input  logic       force_i,
   input  logic       pwm_mode_i,
   input  logic [1:0] com_mode_i,
   input  logic [1:0] wg_act_i,
   input  logic       preset_we_i,
   input  logic       preset_val_i,
   input  logic       port_data_i,
   input  logic       port_dir_i,
   output logic       pin_o,
   output logic       pin_oe_o,
   output logic       ocf_o
);

   oc_act_e act;
   logic    ocf_q;

   tcmp_act_sel u_act_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .match     (cmp_match_i),
      .force_stb (force_i),
      .pwm_mode  (pwm_mode_i),
      .mode_fld  (com_mode_i),
      .wg_act    (wg_act_i),
      .act       (act)
   );

   tcmp_ocff #(.RESET_LEVEL(RESET_LEVEL)) u_ocff (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (act),
      .preset_we  (preset_we_i),
      .preset_val (preset_val_i),
      .q          (ocf_q)
   );

   tcmp_pin_mux #(.HIZ_LEVEL(HIZ_LEVEL)) u_pin_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_fld  (com_mode_i),
      .ocf       (ocf_q),
      .port_data (port_data_i),
      .port_dir  (port_dir_i),
      .pin       (pin_o),
      .pin_oe    (pin_oe_o)
   );

   assign ocf_o = ocf_q;

   // R7: non-PWM force without preset changes state per the mode field
   a_r7_force_acts: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_mode_i && force_i && !preset_we_i && com_mode_i == 2'b11) |=> ocf_o);

endmodule

// File: tb/tcmp_pin_unit_bench.sv
module tcmp_pin_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m = 0, f = 0, pwm = 0, pwe = 0, pval = 0, pdata = 0, pdir = 0;
   logic [1:0] mode = 0, wg = 0;
   logic       pin, oe, ocf;
   logic       q_m;
   int         total = 0, fails = 0;

   always #2 clk = ~clk;

   tcmp_pin_unit u_tcmp_pin_unit (
      .clk(clk), .rst_n(rst_n), .cmp_match_i(m), .force_i(f), .pwm_mode_i(pwm),
      .com_mode_i(mode), .wg_act_i(wg), .preset_we_i(pwe), .preset_val_i(pval),
      .port_data_i(pdata), .port_dir_i(pdir), .pin_o(pin), .pin_oe_o(oe), .ocf_o(ocf)
   );

   task automatic chk(string tag, logic act, logic exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic apply(logic q, logic [1:0] a);
      case (a)
         2'b01:   return ~q;
         2'b10:   return 1'b0;
         2'b11:   return 1'b1;
         default: return q;
      endcase
   endfunction

   // one cycle: set inputs after negedge, check outputs, advance model at posedge
   task automatic cyc(logic im, logic iff_, logic ipwm, logic [1:0] imode, logic [1:0] iwg,
                      logic ipwe, logic ipval, logic idata, logic idir, string tag);
      logic [1:0] a;
      @(negedge clk);
      m = im; f = iff_; pwm = ipwm; mode = imode; wg = iwg;
      pwe = ipwe; pval = ipval; pdata = idata; pdir = idir;
      #1;
      chk({tag, " ocf"}, ocf, q_m);
      chk(idir ? (imode != 0 ? "R3 pin" : "R2 pin") : "R4 pin", pin,
          idir ? (imode != 0 ? q_m : idata) : 1'b0);
      chk("R4 oe", oe, idir);
      @(posedge clk);
      a = 2'b00;
      if (!ipwm && (im || iff_)) a = imode;
      else if (ipwm && im)      a = iwg;
      q_m = ipwe ? ipval : apply(q_m, a);
   endtask

   initial begin
      #(4 * 200000);
      fails++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      q_m = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset ocf", ocf, 1'b0);
      chk("R1 reset oe", oe, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      // R2 port data through, several patterns
      cyc(0,0,0,2'b00,0,0,0,1,1,"R2");
      cyc(0,0,0,2'b00,0,0,0,0,1,"R2");
      cyc(1,0,0,2'b00,0,0,0,1,1,"R5 mode00 match holds");
      cyc(0,0,0,2'b00,0,0,0,1,1,"R5");
      // R10 preset while pin released, R4
      cyc(0,0,0,2'b01,0,1,1,1,0,"R10 preset");
      cyc(0,0,0,2'b01,0,0,0,0,0,"R4 released");
      // R5 toggle / clear / set
      cyc(1,0,0,2'b01,0,0,0,0,1,"R5 toggle");
      cyc(1,0,0,2'b01,0,0,0,1,1,"R5 toggle");
      cyc(1,0,0,2'b10,0,0,0,1,1,"R5 clear");
      cyc(1,0,0,2'b11,0,0,0,0,1,"R5 set");
      cyc(1,0,0,2'b10,0,0,0,0,1,"R5 clear");
      // R6 mode changes without match
      cyc(0,0,0,2'b11,0,0,0,1,1,"R6 no match");
      cyc(0,0,0,2'b01,0,0,0,1,1,"R6 no match");
      cyc(0,0,0,2'b11,0,0,0,1,1,"R6 no match");
      cyc(1,0,0,2'b11,0,0,0,1,1,"R6 match uses current");
      cyc(0,0,0,2'b11,0,0,0,1,1,"R6");
      // R7 force in non-PWM
      cyc(0,1,0,2'b10,0,0,0,1,1,"R7 force clear");
      cyc(0,1,0,2'b01,0,0,0,1,1,"R7 force toggle");
      cyc(0,0,0,2'b01,0,0,0,1,1,"R7");
      // R11 force + match toggle once
      cyc(1,1,0,2'b01,0,0,0,0,1,"R11 single toggle");
      cyc(0,0,0,2'b01,0,0,0,0,1,"R11");
      // R8 force ignored in PWM, R9 waveform action
      cyc(0,1,1,2'b01,2'b01,0,0,1,1,"R8 pwm force");
      cyc(0,1,1,2'b10,2'b11,0,0,1,1,"R8 pwm force");
      cyc(0,0,1,2'b10,0,0,0,1,1,"R8");
      cyc(1,0,1,2'b11,2'b10,0,0,1,1,"R9 wg clear");
      cyc(1,0,1,2'b10,2'b11,0,0,0,1,"R9 wg set");
      cyc(1,0,1,2'b11,2'b01,0,0,0,1,"R9 wg toggle");
      cyc(1,0,1,2'b11,2'b00,0,0,1,1,"R9 wg hold");
      cyc(0,0,1,2'b01,0,0,0,1,1,"R3 pwm override");
      // R10 preset wins over match and force
      cyc(1,1,0,2'b11,0,1,0,1,1,"R10 preset over set");
      cyc(1,0,0,2'b01,0,1,1,1,1,"R10 preset over toggle");
      cyc(0,0,0,2'b01,0,0,0,0,0,"R10");
      cyc(1,0,0,2'b01,0,0,0,0,0,"R4 toggle while released");
      cyc(0,0,0,2'b00,0,0,0,1,1,"R2");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule